// File: doc/BRIEF.md
# Strobe-Windowed Gated One-of-Eight Decoder

This block turns a 3-bit select code into eight active-high lines, at most one of them high. A line may be driven only while an internal window flag is set. The falling edge of an opening strobe sets the flag, and the falling edge of a closing strobe clears it. A chip-select input gates every line. Several copies can therefore share the same select and strobe wiring, and only the chip-selected copy drives a line. This gives multi-level selection of I/O devices. In a command-decoding system, select value 0 is left free by convention. The block still decodes it like any other value.

Both strobes arrive asynchronously to the system clock. Each strobe passes through a synchroniser with SYNC_STAGES flops and then an edge detector. The window flag is a register. The path from the select code and the chip-select input to the output lines is purely combinational, so a change on either input shows at the outputs in the same cycle. Holding the closing strobe low keeps the window open indefinitely once it has been opened, so the opening strobe can be observed on its own. There is no data stream here: all pins are plain control and status signals, with no valid/ready handshake.

Top module: `strobe_gate_dec8`

## Requirements
- R1: With the window set and chip-select high, `dec_o` equals 1 shifted left by `sel_i`: bit k is high exactly when `sel_i == k`, for every k from 0 to 7, including 0.
- R2: After `open_stb_i` goes from 1 to 0, `window_o` is still 0 after two rising clock edges and becomes 1 after the third (SYNC_STAGES = 2).
- R3: After `close_stb_i` goes from 1 to 0, `window_o` becomes 0 after the third rising clock edge, and `dec_o` is then all zeros for every select value.
- R4: While `chip_sel_i` is 0, `dec_o` is all zeros, whatever `sel_i` and `window_o` are.
- R5: Changes on `sel_i` or `chip_sel_i` reach `dec_o` within the same clock cycle, with no clock edge in between.
- R6: While `close_stb_i` stays low, an opened window stays set for any number of cycles, including across further pulses on `open_stb_i`.
- R7: When falling edges of both strobes are detected in the same cycle, the close wins and `window_o` ends up 0.
- R8: While `rst_n` is low at a rising clock edge, `window_o` and `dec_o` become 0, and the synchroniser history is cleared.
- R9: A rising edge on either strobe leaves `window_o` unchanged. This includes a strobe that is high when reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sel_i | input | 3 | Select code |
| open_stb_i | input | 1 | Asynchronous strobe; its falling edge opens the window |
| close_stb_i | input | 1 | Asynchronous strobe; its falling edge closes the window |
| chip_sel_i | input | 1 | Chip select; low forces all lines low |
| dec_o | output | 8 | One-hot decoded lines, active high |
| window_o | output | 1 | Current state of the window flag |

## Verification
The embedded assertions run on every cycle and check four things: the lines are never more than one-hot, exactly one line is high when the gate is open, chip-select low forces zeros, and the window register follows its edge events with close having priority. They also check that no edge detector reports two falls in a row. The bench's sweeps are needed for what only a scenario can show. These are the exact three-edge latency from a strobe pin to the window, the value of every line for all eight codes in both gate states, same-cycle response to select and chip-select changes, a window held open across many cycles and repeated opening pulses, and strobes falling together at the pins.

// File: rtl/sgd_pkg.sv
package sgd_pkg;
  localparam int unsigned SEL_W_DEF   = 3;
  localparam int unsigned STAGES_DEF  = 2;

  typedef enum logic [0:0] {
    STB_OPEN  = 1'b0,
    STB_CLOSE = 1'b1
  } stb_idx_e;

  typedef struct packed {
    logic close_fall;
    logic open_fall;
  } stb_evt_t;
endpackage

// File: rtl/stb_fall_det.sv
module stb_fall_det #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stb_i,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;
  logic              cur;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= stb_i;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], stb_i};
      end
    end
  endgenerate

  assign cur = sync_q[STAGES-1];

  always_ff @(posedge clk) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= cur;
  end

  assign fall_o = last_q & ~cur;

  // R9: one detected fall cannot be followed by another in the next cycle
  p_single_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !fall_o);

  // R8: reset clears the history, so no fall is reported just after it
  p_reset_clear_r8: assert property (@(posedge clk)
    !rst_n |=> !fall_o);
endmodule

// File: rtl/stb_window.sv
module stb_window
  import sgd_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  stb_evt_t evt_i,
  output logic     window_o
);
  logic window_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                window_q <= 1'b0;
    else if (evt_i.close_fall) window_q <= 1'b0;
    else if (evt_i.open_fall)  window_q <= 1'b1;
  end

  assign window_o = window_q;

  // R2: a lone open event sets the window
  p_open_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i.open_fall && !evt_i.close_fall) |=> window_q);

  // R3, R7: a close event always clears, even alongside an open event
  p_close_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    evt_i.close_fall |=> !window_q);

  // R6: without events the window holds
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt_i.close_fall && !evt_i.open_fall) |=> $stable(window_q));

  // R8: reset clears the window
  p_reset_r8: assert property (@(posedge clk)
    !rst_n |=> !window_q);
endmodule

// File: rtl/gated_onehot.sv
module gated_onehot #(
  parameter int unsigned SEL_W = 3,
  localparam int unsigned OUTS = 1 << SEL_W
) (
  input  logic [SEL_W-1:0] sel_i,
  input  logic             gate_i,
  output logic [OUTS-1:0]  dec_o
);
  generate
    for (genvar k = 0; k < OUTS; k++) begin : g_line
      assign dec_o[k] = gate_i && (sel_i == SEL_W'(k));
    end
  endgenerate

  // R1: never more than one line high
  always_comb begin
    a_onehot_r1: assert ($onehot0(dec_o));
  end
endmodule

// File: rtl/strobe_gate_dec8.sv
module strobe_gate_dec8
  import sgd_pkg::*;
#(
  parameter int unsigned SEL_W  = SEL_W_DEF,
  parameter int unsigned STAGES = STAGES_DEF,
  localparam int unsigned OUTS  = 1 << SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             open_stb_i,
  input  logic             close_stb_i,
  input  logic             chip_sel_i,
  output logic [OUTS-1:0]  dec_o,
  output logic             window_o
);
  logic [1:0] stb_raw;
  logic [1:0] stb_fall;
  stb_evt_t   evt;
  logic       gate;

  assign stb_raw[STB_OPEN]  = open_stb_i;
  assign stb_raw[STB_CLOSE] = close_stb_i;

  generate
    for (genvar s = 0; s < 2; s++) begin : g_det
      stb_fall_det #(.STAGES(STAGES)) u_det (
        .clk    (clk),
        .rst_n  (rst_n),
        .stb_i  (stb_raw[s]),
        .fall_o (stb_fall[s])
      );
    end
  endgenerate

  assign evt.open_fall  = stb_fall[STB_OPEN];
  assign evt.close_fall = stb_fall[STB_CLOSE];

  stb_window u_win (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt_i    (evt),
    .window_o (window_o)
  );

  assign gate = window_o & chip_sel_i;

  gated_onehot #(.SEL_W(SEL_W)) u_dec (
    .sel_i  (sel_i),
    .gate_i (gate),
    .dec_o  (dec_o)
  );

  // R4: chip select low forces all lines low
  p_chip_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_sel_i |-> (dec_o == '0));

  // R1: open gate gives exactly one high line
  p_one_line_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (window_o && chip_sel_i) |-> ($countones(dec_o) == 1));

  // R3: closed window gives no high line
  p_closed_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !window_o |-> (dec_o == '0));
endmodule

// File: tb/tb_strobe_gate_dec8.sv
module tb_strobe_gate_dec8;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] sel_i;
  logic       open_stb_i, close_stb_i, chip_sel_i;
  logic [7:0] dec_o;
  logic       window_o;

  int n_cmp = 0;
  int n_bad = 0;

  strobe_gate_dec8 dut (
    .clk(clk), .rst_n(rst_n), .sel_i(sel_i),
    .open_stb_i(open_stb_i), .close_stb_i(close_stb_i),
    .chip_sel_i(chip_sel_i), .dec_o(dec_o), .window_o(window_o)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // advance n rising edges, then settle a quarter period past the edge
  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #(CLK_P/4);
  endtask

  function automatic logic [7:0] model(input logic [2:0] s, input logic cs, input logic w);
    return (cs && w) ? (8'd1 << s) : 8'd0;
  endfunction

  task automatic sweep(input string tag, input logic cs, input logic w);
    for (int s = 0; s < 8; s++) begin
      sel_i = 3'(s);
      #1;
      chk(tag, dec_o, model(3'(s), cs, w));
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_P * 200000);
    n_bad++;
    $display("FAIL R8 watchdog actual=timeout expected=done");
    summary();
  end

  initial begin
    rst_n = 1'b0; sel_i = 3'd3; chip_sel_i = 1'b1;
    open_stb_i = 1'b1; close_stb_i = 1'b1;
    tick(3);
    chk("R8 reset window", {7'd0, window_o}, 8'd0);
    chk("R8 reset lines", dec_o, 8'd0);

    rst_n = 1'b1;
    tick(5);
    chk("R9 high strobes after reset", {7'd0, window_o}, 8'd0);

    // open: latency check
    open_stb_i = 1'b0;
    tick(2);
    chk("R2 not yet open", {7'd0, window_o}, 8'd0);
    tick(1);
    chk("R2 open", {7'd0, window_o}, 8'd1);

    sweep("R1 decode cs=1", 1'b1, 1'b1);
    chip_sel_i = 1'b0;
    sweep("R4 decode cs=0", 1'b0, 1'b1);

    // R5: chip select toggled mid-window, same cycle response
    sel_i = 3'd5;
    chip_sel_i = 1'b1; #1;
    chk("R5 cs rise", dec_o, 8'h20);
    chip_sel_i = 1'b0; #1;
    chk("R5 cs fall", dec_o, 8'h00);
    chip_sel_i = 1'b1; sel_i = 3'd0; #1;
    chk("R5 sel change", dec_o, 8'h01);

    // R9: rising open strobe has no effect
    open_stb_i = 1'b1;
    tick(5);
    chk("R9 open rise", {7'd0, window_o}, 8'd1);

    // close
    close_stb_i = 1'b0;
    tick(2);
    chk("R3 still open", {7'd0, window_o}, 8'd1);
    tick(1);
    chk("R3 closed", {7'd0, window_o}, 8'd0);
    sweep("R3 closed lines", 1'b1, 1'b0);

    // R6: close held low, window stays open
    open_stb_i = 1'b0;
    tick(3);
    chk("R6 reopen", {7'd0, window_o}, 8'd1);
    for (int c = 0; c < 4; c++) begin
      tick(12);
      open_stb_i = ~open_stb_i;
      chk("R6 held open", {7'd0, window_o}, 8'd1);
    end
    open_stb_i = 1'b1;
    tick(40);
    chk("R6 long hold", {7'd0, window_o}, 8'd1);
    sel_i = 3'd7; #1;
    chk("R6 line", dec_o, 8'h80);

    // R7: simultaneous falls from open state
    close_stb_i = 1'b1;
    tick(5);
    chk("R9 close rise", {7'd0, window_o}, 8'd1);
    open_stb_i = 1'b0; close_stb_i = 1'b0;
    tick(4);
    chk("R7 close wins", {7'd0, window_o}, 8'd0);
    chk("R7 lines low", dec_o, 8'd0);

    // R7: simultaneous falls from closed state
    open_stb_i = 1'b1; close_stb_i = 1'b1;
    tick(5);
    open_stb_i = 1'b0; close_stb_i = 1'b0;
    tick(4);
    chk("R7 stays closed", {7'd0, window_o}, 8'd0);

    // R8: reset while open
    open_stb_i = 1'b1; close_stb_i = 1'b1;
    tick(4);
    open_stb_i = 1'b0;
    tick(3);
    chk("R2 open again", {7'd0, window_o}, 8'd1);
    rst_n = 1'b0;
    tick(1);
    chk("R8 reset mid-window", {7'd0, window_o}, 8'd0);
    chk("R8 reset lines mid", dec_o, 8'd0);
    rst_n = 1'b1;
    tick(5);
    chk("R8 low strobe no false open", {7'd0, window_o}, 8'd0);

    summary();
  end
endmodule